// File: doc/BRIEF.md
# Channel Status Flag Clear Unit

This block keeps two per-channel status vectors for a multichannel DMA engine: one holds pending interrupt-request flags, the other holds error flags, one bit per channel in each. The transfer datapath raises flags through per-channel set inputs. Software lowers them by writing encoded byte commands into a 32-bit, write-only command word. The command word is not a bit mask.

Each command byte carries three fields. A skip bit makes the whole byte inert. A wipe bit clears the whole targeted vector. A channel index names the single flag to clear. Two adjacent byte lanes of the command word hold these commands: the low lane targets the interrupt flags and the next lane targets the error flags. The skip bit lets software write the whole word in one access and still leave selected lanes without effect. The upper two lanes are accepted on the bus and do nothing here. Both vectors are visible as read-only outputs.

The flag registers reset asynchronously through an active-low reset. The reset is expected to be released synchronously to the clock by the surrounding reset logic.

Top module: `chflag_clear_unit`

## Requirements
- R1: While rst_n is low, both irq_flags and err_flags are all zeros.
- R2: A 1 on bit c of irq_set (or err_set) makes bit c of irq_flags (or err_flags) 1 after the next rising clock edge. Without a set or a clear command, every flag keeps its value.
- R3: A write with wr_en=1, wr_be[0]=1 and a word address hit, where wr_data[7]=0 and wr_data[6]=0, clears irq_flags bit wr_data[5:0] at the next rising edge. All other interrupt flags are left alone.
- R4: A write with wr_be[1]=1 and a word address hit, where wr_data[15]=0 and wr_data[14]=0, clears err_flags bit wr_data[13:8] at the next rising edge. All other error flags are left alone.
- R5: In a command byte whose skip bit is 0, a 1 in bit 6 of the byte (command values 64 to 127) clears every flag of the targeted vector, whatever the index bits hold.
- R6: A command byte whose bit 7 (skip bit) is 1 changes no flag.
- R7: A command lane whose wr_be bit is 0 changes no flag, whatever its data.
- R8: Byte lanes 2 and 3 (wr_data[31:16]) change no flag.
- R9: A write is decoded only when wr_addr[7:2] equals CMD_ADDR[7:2] (default byte address 0x1C). Address bits [1:0] are ignored, and writes to any other word change no flag.
- R10: An interrupt-clear byte and an error-clear byte in the same write both take effect at the same clock edge.
- R11: When a set input and a clear command hit the same flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (8) | Byte address of the written word |
| wr_be | input | DATA_W/8 (4) | Byte-lane enables, bit n for wr_data[8n+7:8n] |
| wr_data | input | DATA_W (32) | Write data carrying the command bytes |
| irq_set | input | NUM_CH (64) | Per-channel interrupt-request set pulses |
| err_set | input | NUM_CH (64) | Per-channel error set pulses |
| irq_flags | output | NUM_CH (64) | Current interrupt-request flags |
| err_flags | output | NUM_CH (64) | Current error flags |

## Verification
The bench targets several commands that are easy to misdecode:
- A byte with both the skip bit and an index set. A design that tests the index before the skip bit would clear a channel.
- A wipe byte whose index bits are nonzero. A design that ignores bit 6 would clear one channel instead of all.
- Lane data present with its strobe low, data in the two upper lanes, and writes to a neighbouring word. A design that decodes too loosely would clear flags on any of these.
- Index 63 and index 0. An off-by-one in the index compare would hit the wrong bit.
- A set and a clear on the same channel in the same cycle. A design where the clear takes priority would lose a fresh event.

// File: rtl/chfc_pkg.sv
package chfc_pkg;

  localparam int LANE_W = 8;
  localparam int IDX_W  = 6;

  // Layout of one command byte, most significant field first.
  typedef struct packed {
    logic             skip;
    logic             wipe;
    logic [IDX_W-1:0] idx;
  } chfc_cmd_t;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_ONE  = 2'd1,
    ACT_ALL  = 2'd2
  } chfc_act_e;

  // The skip bit dominates: nothing else in the byte is looked at when it is set.
  function automatic chfc_act_e chfc_classify(input logic lane_en, input chfc_cmd_t cmd);
    if (!lane_en || cmd.skip) return ACT_IDLE;
    if (cmd.wipe)             return ACT_ALL;
    return ACT_ONE;
  endfunction

endpackage

// File: rtl/chfc_addr_match.sv
module chfc_addr_match #(
  parameter int                NUM_LANES = 4,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h1C
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_LANES-1:0] wr_be,
  output logic [NUM_LANES-1:0] lane_en
);

  localparam int OFS_W = $clog2(NUM_LANES);

  logic word_hit;
  logic unused_ofs;

  always_comb begin
    word_hit = wr_en && (wr_addr[ADDR_W-1:OFS_W] == CMD_ADDR[ADDR_W-1:OFS_W]);
    lane_en  = word_hit ? wr_be : '0;
  end

  assign unused_ofs = ^wr_addr[OFS_W-1:0];

endmodule

// File: rtl/chfc_lane_decode.sv
module chfc_lane_decode
  import chfc_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              lane_en,
  input  logic [LANE_W-1:0] cmd_byte,
  output logic [NUM_CH-1:0] clr_mask
);

  chfc_cmd_t cmd;
  chfc_act_e act;

  always_comb begin
    cmd = chfc_cmd_t'(cmd_byte);
    act = chfc_classify(lane_en, cmd);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign clr_mask[c] = (act == ACT_ALL) ||
                         ((act == ACT_ONE) && (cmd.idx == IDX_W'(c)));
  end

endmodule

// File: rtl/chfc_flag_bank.sv
module chfc_flag_bank #(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flags_o
);

  logic [NUM_CH-1:0] flags_q;
  logic [NUM_CH-1:0] flags_d;
  logic              upd_en;

  // Set is ORed in after the clear, so a same-cycle event survives.
  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
    upd_en  = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/chflag_clear_unit.sv
module chflag_clear_unit
  import chfc_pkg::*;
#(
  parameter int                NUM_CH   = 64,
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h1C,
  parameter int                IRQ_LANE = 0,
  parameter int                ERR_LANE = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W/LANE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [NUM_CH-1:0]          irq_set,
  input  logic [NUM_CH-1:0]          err_set,
  output logic [NUM_CH-1:0]          irq_flags,
  output logic [NUM_CH-1:0]          err_flags
);

  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int NUM_BANKS = 2;

  logic [NUM_LANES-1:0] lane_en;
  logic [NUM_CH-1:0]    set_v  [NUM_BANKS];
  logic [NUM_CH-1:0]    clr_v  [NUM_BANKS];
  logic [NUM_CH-1:0]    flag_v [NUM_BANKS];
  logic                 unused_bits;

  chfc_addr_match #(
    .NUM_LANES (NUM_LANES),
    .ADDR_W    (ADDR_W),
    .CMD_ADDR  (CMD_ADDR)
  ) u_match (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_be   (wr_be),
    .lane_en (lane_en)
  );

  assign set_v[0]  = irq_set;
  assign set_v[1]  = err_set;
  assign irq_flags = flag_v[0];
  assign err_flags = flag_v[1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LANE = (b == 0) ? IRQ_LANE : ERR_LANE;

    chfc_lane_decode #(
      .NUM_CH (NUM_CH)
    ) u_dec (
      .lane_en  (lane_en[LANE]),
      .cmd_byte (wr_data[LANE*LANE_W +: LANE_W]),
      .clr_mask (clr_v[b])
    );

    chfc_flag_bank #(
      .NUM_CH (NUM_CH)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_v[b]),
      .clr_i   (clr_v[b]),
      .flags_o (flag_v[b])
    );
  end

  // Lanes without a command register are accepted and dropped.
  assign unused_bits = ^{wr_data, lane_en};

endmodule

// File: rtl/chflag_clear_unit_chk.sv
module chflag_clear_unit_chk #(
  parameter int                NUM_CH   = 64,
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h1C,
  parameter int                IRQ_LANE = 0,
  parameter int                ERR_LANE = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W/8-1:0] wr_be,
  input logic [DATA_W-1:0]   wr_data,
  input logic [NUM_CH-1:0]   irq_set,
  input logic [NUM_CH-1:0]   err_set,
  input logic [NUM_CH-1:0]   irq_flags,
  input logic [NUM_CH-1:0]   err_flags
);

  logic       hit, irq_go, err_go, irq_all, err_all;
  logic [5:0] irq_idx, err_idx;

  always_comb begin
    hit     = wr_en && (wr_addr[ADDR_W-1:2] == CMD_ADDR[ADDR_W-1:2]);
    irq_go  = hit && wr_be[IRQ_LANE] && !wr_data[IRQ_LANE*8+7];
    err_go  = hit && wr_be[ERR_LANE] && !wr_data[ERR_LANE*8+7];
    irq_all = irq_go && wr_data[IRQ_LANE*8+6];
    err_all = err_go && wr_data[ERR_LANE*8+6];
    irq_idx = wr_data[IRQ_LANE*8 +: 6];
    err_idx = wr_data[ERR_LANE*8 +: 6];
  end

  // R2 R6 R7 R8 R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_go |=> irq_flags == ($past(irq_flags) | $past(irq_set)));

  // R2 R6 R7 R8 R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_go |=> err_flags == ($past(err_flags) | $past(err_set)));

  // R5
  irq_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_all |=> irq_flags == $past(irq_set));

  // R5
  err_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_all |=> err_flags == $past(err_set));

  // R3
  irq_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_go && !irq_all) |=> irq_flags[$past(irq_idx)] == $past(irq_set[irq_idx]));

  // R4
  err_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_go && !err_all) |=> err_flags[$past(err_idx)] == $past(err_set[err_idx]));

  // R11
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> (irq_flags & $past(irq_set)) == $past(irq_set));

  // R11
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> (err_flags & $past(err_set)) == $past(err_set));

endmodule

bind chflag_clear_unit chflag_clear_unit_chk #(
  .NUM_CH   (NUM_CH),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .CMD_ADDR (CMD_ADDR),
  .IRQ_LANE (IRQ_LANE),
  .ERR_LANE (ERR_LANE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_be     (wr_be),
  .wr_data   (wr_data),
  .irq_set   (irq_set),
  .err_set   (err_set),
  .irq_flags (irq_flags),
  .err_flags (err_flags)
);

// File: tb/chflag_clear_unit_bench.sv
module chflag_clear_unit_bench;

  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_ONE  = 2'd1;
  localparam logic [1:0] K_ALL  = 2'd2;

  typedef struct packed {
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [1:0]  ik;
    logic [5:0]  ich;
    logic [1:0]  ek;
    logic [5:0]  ech;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h1C, 4'b0001, 32'h0000_0005, K_ONE,  6'd5,  K_NONE, 6'd0,  8'd3},  // R3
    '{8'h1C, 4'b0010, 32'h0000_2A00, K_NONE, 6'd0,  K_ONE,  6'd42, 8'd4},  // R4
    '{8'h1C, 4'b0011, 32'h0000_3F00, K_ONE,  6'd0,  K_ONE,  6'd63, 8'd10}, // R10
    '{8'h1C, 4'b0001, 32'h0000_0045, K_ALL,  6'd0,  K_NONE, 6'd0,  8'd5},  // R5
    '{8'h1C, 4'b0010, 32'h0000_7F00, K_NONE, 6'd0,  K_ALL,  6'd0,  8'd5},  // R5
    '{8'h1C, 4'b0001, 32'h0000_00C5, K_NONE, 6'd0,  K_NONE, 6'd0,  8'd6},  // R6
    '{8'h1C, 4'b0011, 32'h0000_8003, K_ONE,  6'd3,  K_NONE, 6'd0,  8'd6},  // R6
    '{8'h1C, 4'b0010, 32'h0000_0007, K_NONE, 6'd0,  K_ONE,  6'd0,  8'd7},  // R7
    '{8'h1C, 4'b1100, 32'h0505_0000, K_NONE, 6'd0,  K_NONE, 6'd0,  8'd8},  // R8
    '{8'h1C, 4'b1111, 32'h4142_0809, K_ONE,  6'd9,  K_ONE,  6'd8,  8'd8},  // R8
    '{8'h18, 4'b1111, 32'h0000_0101, K_NONE, 6'd0,  K_NONE, 6'd0,  8'd9},  // R9
    '{8'h1F, 4'b0001, 32'h0000_0002, K_ONE,  6'd2,  K_NONE, 6'd0,  8'd9},  // R9
    '{8'h20, 4'b0011, 32'h0000_4040, K_NONE, 6'd0,  K_NONE, 6'd0,  8'd9}   // R9
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [63:0] irq_set;
  logic [63:0] err_set;
  logic [63:0] irq_flags;
  logic [63:0] err_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  chflag_clear_unit u_chflag_clear_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .irq_set   (irq_set),
    .err_set   (err_set),
    .irq_flags (irq_flags),
    .err_flags (err_flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] expv(input logic [1:0] k, input logic [5:0] ch);
    case (k)
      K_ONE:   return ~(64'd1 << ch);
      K_ALL:   return 64'd0;
      default: return {64{1'b1}};
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_addr = 8'h0; wr_be = 4'h0; wr_data = 32'h0;
    irq_set = '0; err_set = '0;
  endtask

  task automatic fill_all();
    @(negedge clk);
    irq_set = {64{1'b1}}; err_set = {64{1'b1}};
    @(negedge clk);
    irq_set = '0; err_set = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1", "irq after reset", irq_flags, 64'd0);
    check("R1", "err after reset", err_flags, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      fill_all();
      wr_en = 1'b1; wr_addr = VECS[i].addr; wr_be = VECS[i].be; wr_data = VECS[i].data;
      @(negedge clk);
      idle_inputs();
      check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d irq", i),
            irq_flags, expv(VECS[i].ik, VECS[i].ich));
      check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d err", i),
            err_flags, expv(VECS[i].ek, VECS[i].ech));
    end

    // R5 both wiped together from all ones
    fill_all();
    wr_en = 1'b1; wr_addr = 8'h1C; wr_be = 4'b0011; wr_data = 32'h0000_4040;
    @(negedge clk);
    idle_inputs();
    check("R5", "irq wipe", irq_flags, 64'd0);
    check("R5", "err wipe", err_flags, 64'd0);

    // R2 set raises a single flag, then holds
    irq_set = 64'd1 << 17; err_set = 64'd1 << 33;
    @(negedge clk);
    idle_inputs();
    check("R2", "irq set", irq_flags, 64'd1 << 17);
    check("R2", "err set", err_flags, 64'd1 << 33);
    repeat (3) @(negedge clk);
    check("R2", "irq hold", irq_flags, 64'd1 << 17);
    check("R2", "err hold", err_flags, 64'd1 << 33);

    // R11 set and single clear on the same channel
    irq_set = 64'd1 << 20;
    wr_en = 1'b1; wr_addr = 8'h1C; wr_be = 4'b0001; wr_data = 32'h0000_0014;
    @(negedge clk);
    idle_inputs();
    check("R11", "irq set beats clear", irq_flags, (64'd1 << 17) | (64'd1 << 20));

    // R11 set during a wipe of the error vector
    err_set = 64'd1 << 50;
    wr_en = 1'b1; wr_addr = 8'h1C; wr_be = 4'b0010; wr_data = 32'h0000_4000;
    @(negedge clk);
    idle_inputs();
    check("R11", "err set beats wipe", err_flags, 64'd1 << 50);

    // R1 reset in mid-run
    fill_all();
    rst_n = 1'b0;
    #1;
    check("R1", "irq async reset", irq_flags, 64'd0);
    check("R1", "err async reset", err_flags, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "irq after release", irq_flags, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule